// File: doc/BRIEF.md
# Ternary Controlled Modular-Add Gate

This block is a reversible gate over multiple-valued wires. Each wire carries one digit on two bits. The control wires pass to the outputs untouched. The target wire leaves as its input plus a control function of the controls, summed modulo 3 in ternary mode and XOR-ed in binary mode. Because that sum has an inverse for every fixed control value, the gate maps its input vectors one-to-one even when the control function is irreversible.

The control function is read from a nine-entry table that software loads one entry per clock. In the one-control form the function is indexed by the first control alone. In the two-control form it is indexed by both controls. The data path is combinational. Only the table holds state. Any digit code that is illegal for the current radix raises an error flag and clears the outputs.

Top module: `tern_toffoli_gate`

## Requirements
- R1: When `code_err` is low, `a_out` equals `a_in` and `b_out` equals `b_in`, in every mode.
- R2: In ternary mode (`radix3`=1) with `code_err` low, `c_out` = (`c_in` + f) mod 3. f is table entry `a_in` in the one-control form (`two_ctl`=0) and entry 3·`a_in`+`b_in` in the two-control form.
- R3: Ternary digits are coded 00=0, 01=1 and 10=2. The code 11 on `a_in` or `c_in`, or on `b_in` in the two-control form, sets `code_err`.
- R4: Whenever `code_err` is high, `a_out`, `b_out` and `c_out` are all 00.
- R5: In binary mode (`radix3`=0), a digit with bit 1 set is illegal and sets `code_err`. The target is `c_out` = `c_in` XOR f.
- R6: In binary mode, the one-control form uses f = `a_in`[0] XOR bit 0 of entry 0, so f is identity when that bit is 0 and NOT when it is 1. The two-control form uses f = bit 0 of entry 3·`a_in`+`b_in`.
- R7: With `tbl_we` high at a rising clock edge, entry `tbl_addr` (0..8) takes `tbl_data`, and the new entry is visible after that edge. A write to an address of 9 or more changes no entry.
- R8: Reset clears every entry to 00, so after reset `c_out` equals `c_in`.
- R9: In ternary mode, a selected table entry holding 11 sets `code_err`.
- R10: In the one-control form, `b_in` is not checked and does not affect f. It appears unchanged on `b_out`.
- R11: For any loaded table, in each mode, all legal input vectors give pairwise distinct output vectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for table writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 4 | Table entry address |
| tbl_data | input | 2 | Entry value to write |
| radix3 | input | 1 | 1 = ternary modulo-3, 0 = binary XOR |
| two_ctl | input | 1 | 1 = two-control form, 0 = one-control form |
| a_in | input | 2 | First control digit |
| b_in | input | 2 | Second control digit |
| c_in | input | 2 | Target digit |
| a_out | output | 2 | First control, passed through |
| b_out | output | 2 | Second control, passed through |
| c_out | output | 2 | Updated target |
| code_err | output | 1 | Illegal digit code seen |

## Verification
The hardest property to reach from the ports is that the gate stays one-to-one under an irreversible control function. It can only be seen across a whole set of inputs, never from a single vector. The bench therefore loads several tables, among them a constant one and many-to-one ones, and in every mode sweeps all legal input vectors. It records each output vector in a seen-set and flags any repeat. An illegal entry can only reach the data path through the load port, so the bench writes 11 into an entry and then selects that entry.

// File: rtl/tern_pkg.sv
package tern_pkg;
  localparam int DIG_W       = 2;
  localparam int NUM_ENTRIES = 9;
  localparam int IDX_W       = $clog2(NUM_ENTRIES + 1);
  localparam int RADIX       = 3;

  typedef logic [DIG_W-1:0] digit_t;
  typedef logic [IDX_W-1:0] idx_t;

  localparam digit_t DIG_BAD = 2'b11;
endpackage

// File: rtl/tern_digit_check.sv
module tern_digit_check
  import tern_pkg::*;
(
  input  digit_t dig,
  input  logic   radix3,
  input  logic   en,
  output logic   bad
);
  always_comb begin
    if (!en)
      bad = 1'b0;
    else if (radix3)
      bad = (dig == DIG_BAD);
    else
      bad = dig[DIG_W-1];
  end
endmodule

// File: rtl/tern_fn_table.sv
module tern_fn_table
  import tern_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  idx_t   wr_addr,
  input  digit_t wr_data,
  input  idx_t   rd_idx,
  output digit_t rd_data,
  output digit_t entry0
);
  digit_t mem_q [NUM_ENTRIES];
  digit_t mem_d [NUM_ENTRIES];

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (wr_en && (wr_addr == idx_t'(i)))
        mem_d[i] = wr_data;
      else
        mem_d[i] = mem_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) mem_q[i] <= mem_d[i];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (rd_idx == idx_t'(i)) rd_data = mem_q[i];
  end

  assign entry0 = mem_q[0];
endmodule

// File: rtl/tern_group_add.sv
module tern_group_add
  import tern_pkg::*;
(
  input  logic   radix3,
  input  digit_t tgt,
  input  digit_t fval,
  output digit_t sum
);
  logic [DIG_W:0] raw;

  always_comb begin
    raw = {1'b0, tgt} + {1'b0, fval};
    if (radix3)
      sum = (raw >= (DIG_W+1)'(RADIX)) ? DIG_W'(raw - (DIG_W+1)'(RADIX)) : raw[DIG_W-1:0];
    else
      sum = {1'b0, tgt[0] ^ fval[0]};
  end
endmodule

// File: rtl/tern_toffoli_gate.sv
module tern_toffoli_gate
  import tern_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tbl_we,
  input  logic [3:0] tbl_addr,
  input  logic [1:0] tbl_data,
  input  logic       radix3,
  input  logic       two_ctl,
  input  logic [1:0] a_in,
  input  logic [1:0] b_in,
  input  logic [1:0] c_in,
  output logic [1:0] a_out,
  output logic [1:0] b_out,
  output logic [1:0] c_out,
  output logic       code_err
);
  localparam int NDIG = 3;

  digit_t            digs [NDIG];
  logic [NDIG-1:0]   dig_en;
  logic [NDIG-1:0]   dig_bad;
  idx_t              rd_idx;
  digit_t            tbl_word;
  digit_t            tbl_e0;
  digit_t            f_sel;
  digit_t            sum;
  logic              tbl_bad;

  assign digs[0]   = a_in;
  assign digs[1]   = b_in;
  assign digs[2]   = c_in;
  assign dig_en    = {1'b1, two_ctl, 1'b1};

  for (genvar g = 0; g < NDIG; g++) begin : g_chk
    tern_digit_check u_chk (
      .dig   (digs[g]),
      .radix3(radix3),
      .en    (dig_en[g]),
      .bad   (dig_bad[g])
    );
  end

  always_comb begin
    if (two_ctl)
      rd_idx = idx_t'(a_in) * idx_t'(RADIX) + idx_t'(b_in);
    else
      rd_idx = idx_t'(a_in);
  end

  tern_fn_table u_tbl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tbl_we),
    .wr_addr(tbl_addr),
    .wr_data(tbl_data),
    .rd_idx (rd_idx),
    .rd_data(tbl_word),
    .entry0 (tbl_e0)
  );

  always_comb begin
    if (radix3)
      f_sel = tbl_word;
    else if (two_ctl)
      f_sel = {1'b0, tbl_word[0]};
    else
      f_sel = {1'b0, a_in[0] ^ tbl_e0[0]};
  end

  assign tbl_bad = radix3 && (tbl_word == DIG_BAD);

  tern_group_add u_add (
    .radix3(radix3),
    .tgt   (c_in),
    .fval  (f_sel),
    .sum   (sum)
  );

  always_comb begin
    code_err = |dig_bad || tbl_bad;
    if (code_err) begin
      a_out = '0;
      b_out = '0;
      c_out = '0;
    end else begin
      a_out = a_in;
      b_out = b_in;
      c_out = sum;
    end
  end
endmodule

// File: rtl/tern_toffoli_chk.sv
module tern_toffoli_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       radix3,
  input logic       two_ctl,
  input logic [1:0] a_in,
  input logic [1:0] b_in,
  input logic [1:0] c_in,
  input logic [1:0] a_out,
  input logic [1:0] b_out,
  input logic [1:0] c_out,
  input logic       code_err,
  input logic [1:0] f_sel
);
  a_r1_ctrl_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !code_err |-> (a_out == a_in && b_out == b_in));

  a_r4_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> (a_out == 2'b00 && b_out == 2'b00 && c_out == 2'b00));

  a_r2_mod3_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (radix3 && !code_err) |-> (({1'b0, c_out} + 3'd3 - {1'b0, c_in}) % 3'd3 == {1'b0, f_sel} % 3'd3));

  a_r5_bin_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (!radix3 && !code_err) |-> (c_out[1] == 1'b0 && (c_out[0] ^ c_in[0]) == f_sel[0]));

  a_r3_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    (radix3 && (a_in == 2'b11 || c_in == 2'b11 || (two_ctl && b_in == 2'b11))) |-> code_err);

  a_r9_legal_out: assert property (@(posedge clk) disable iff (!rst_n)
    (radix3 && !code_err) |-> (c_out != 2'b11));
endmodule

bind tern_toffoli_gate tern_toffoli_chk u_toffoli_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .radix3  (radix3),
  .two_ctl (two_ctl),
  .a_in    (a_in),
  .b_in    (b_in),
  .c_in    (c_in),
  .a_out   (a_out),
  .b_out   (b_out),
  .c_out   (c_out),
  .code_err(code_err),
  .f_sel   (f_sel)
);

// File: tb/test_tern_toffoli_gate.sv
module test_tern_toffoli_gate;
  logic       clk;
  logic       rst_n;
  logic       tbl_we;
  logic [3:0] tbl_addr;
  logic [1:0] tbl_data;
  logic       radix3;
  logic       two_ctl;
  logic [1:0] a_in, b_in, c_in;
  logic [1:0] a_out, b_out, c_out;
  logic       code_err;

  int n_chk  = 0;
  int n_fail = 0;

  tern_toffoli_gate i_tern_toffoli_gate (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_data(tbl_data), .radix3(radix3), .two_ctl(two_ctl),
    .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .a_out(a_out), .b_out(b_out), .c_out(c_out), .code_err(code_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // fields: r3, tc, a, b, c, exp_c, exp_err
  // loaded table: 1,2,0,2,0,1,1,1,2
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1,1'b1,2'd1,2'd2,2'd1,2'd2,1'b0}, // R2 idx5
    {1'b1,1'b1,2'd2,2'd2,2'd2,2'd1,1'b0}, // R2 idx8 wrap
    {1'b1,1'b1,2'd0,2'd0,2'd0,2'd1,1'b0}, // R2 idx0
    {1'b1,1'b0,2'd2,2'd1,2'd2,2'd2,1'b0}, // R2 one-ctl idx2
    {1'b1,1'b0,2'd1,2'd2,2'd2,2'd1,1'b0}, // R2 one-ctl idx1
    {1'b1,1'b1,2'd3,2'd0,2'd0,2'd0,1'b1}, // R3 bad a
    {1'b1,1'b0,2'd0,2'd3,2'd1,2'd2,1'b0}, // R10 b unchecked
    {1'b1,1'b1,2'd0,2'd1,2'd3,2'd0,1'b1}, // R3 bad c
    {1'b0,1'b0,2'd1,2'd0,2'd0,2'd0,1'b0}, // R6 NOT
    {1'b0,1'b0,2'd0,2'd0,2'd1,2'd0,1'b0}, // R6 NOT
    {1'b0,1'b1,2'd1,2'd1,2'd0,2'd0,1'b0}, // R6 idx4
    {1'b0,1'b1,2'd0,2'd1,2'd1,2'd1,1'b0}, // R6 idx1
    {1'b0,1'b1,2'd0,2'd0,2'd0,2'd1,1'b0}, // R5 idx0
    {1'b0,1'b0,2'd2,2'd0,2'd0,2'd0,1'b1}  // R5 bad binary
  };
  localparam logic [1:0] TBL [9] = '{2'd1,2'd2,2'd0,2'd2,2'd0,2'd1,2'd1,2'd1,2'd2};

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] ad, input logic [1:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = ad; tbl_data = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic apply(input logic r, input logic t, input logic [1:0] a,
                       input logic [1:0] b, input logic [1:0] c);
    @(negedge clk);
    radix3 = r; two_ctl = t; a_in = a; b_in = b; c_in = c;
    #1;
  endtask

  // R11: sweep every legal input in one mode, look for repeated outputs
  task automatic sweep(input logic r, input logic t, input string tag);
    bit seen [64];
    int dup = 0;
    int errs = 0;
    int lim = r ? 3 : 2;
    for (int i = 0; i < 64; i++) seen[i] = 1'b0;
    for (int a = 0; a < lim; a++)
      for (int b = 0; b < (t ? lim : 1); b++)
        for (int c = 0; c < lim; c++) begin
          apply(r, t, 2'(a), 2'(b), 2'(c));
          if (code_err) errs++;
          if (seen[{a_out, b_out, c_out}]) dup++;
          seen[{a_out, b_out, c_out}] = 1'b1;
        end
    check({"R11 ", tag}, 7'(dup + errs), 7'd0);
  endtask

  initial begin
    rst_n = 1'b0; tbl_we = 1'b0; tbl_addr = '0; tbl_data = '0;
    radix3 = 1'b1; two_ctl = 1'b1; a_in = '0; b_in = '0; c_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset table is all zero, identity
    apply(1'b1, 1'b1, 2'd2, 2'd1, 2'd2);
    check("R8 reset identity", {a_out, b_out, c_out, code_err}, {2'd2, 2'd1, 2'd2, 1'b0});
    apply(1'b1, 1'b0, 2'd1, 2'd0, 2'd1);
    check("R8 reset identity one-ctl", {a_out, b_out, c_out, code_err}, {2'd1, 2'd0, 2'd1, 1'b0});

    // R7: write then observe next
    wr(4'd4, 2'd2);
    apply(1'b1, 1'b1, 2'd1, 2'd1, 2'd2);
    check("R7 write visible", {a_out, b_out, c_out, code_err}, {2'd1, 2'd1, 2'd1, 1'b0});
    wr(4'd9, 2'd2);
    for (int k = 0; k < 9; k++) begin
      if (k == 4) continue;
      apply(1'b1, 1'b1, 2'(k / 3), 2'(k % 3), 2'd0);
      check("R7 out-of-range write ignored", {a_out, b_out, c_out, code_err},
            {2'(k / 3), 2'(k % 3), 2'd0, 1'b0});
    end

    for (int k = 0; k < 9; k++) wr(4'(k), TBL[k]);
    for (int v = 0; v < NV; v++) begin
      logic [10:0] e;
      e = VEC[v];
      apply(e[10], e[9], e[8:7], e[6:5], e[4:3]);
      if (e[0])
        check("R3/R4/R5 vector err", {a_out, b_out, c_out, code_err}, {6'd0, 1'b1});
      else
        check("R1/R2/R6/R10 vector", {a_out, b_out, c_out, code_err},
              {e[8:7], e[6:5], e[2:1], 1'b0});
    end

    // R9: illegal entry selected in ternary, harmless in binary
    wr(4'd3, 2'd3);
    apply(1'b1, 1'b1, 2'd1, 2'd0, 2'd1);
    check("R9 bad entry", {a_out, b_out, c_out, code_err}, {6'd0, 1'b1});
    apply(1'b0, 1'b1, 2'd1, 2'd0, 2'd0);
    check("R6 bad entry binary bit0", {a_out, b_out, c_out, code_err}, {2'd1, 2'd0, 2'd1, 1'b0});

    // R11 with the irreversible loaded table
    wr(4'd3, 2'd2);
    sweep(1'b1, 1'b1, "tern two-ctl");
    sweep(1'b1, 1'b0, "tern one-ctl");
    sweep(1'b0, 1'b1, "bin two-ctl");
    sweep(1'b0, 1'b0, "bin one-ctl");
    // constant table
    for (int k = 0; k < 9; k++) wr(4'(k), 2'd2);
    sweep(1'b1, 1'b1, "const tern");
    wr(4'd0, 2'd1);
    sweep(1'b0, 1'b0, "bin NOT");
    // many-to-one table
    for (int k = 0; k < 9; k++) wr(4'(k), 2'((k * k) % 3));
    sweep(1'b1, 1'b1, "square tern");
    sweep(1'b0, 1'b1, "square bin");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule